// File: doc/BRIEF.md
# Hamming(7,4) Serial Transmitter with Error-Driven Resend

This block accepts a 4-bit result word on a load strobe and protects it with three parity bits, forming a 7-bit single-error-correcting codeword. The codeword is kept in a holding register. It is then shifted out one bit per clock, with a frame-valid qualifier, to an external receiver that checks it.

After the last bit of each frame the block spends one cycle waiting for the receiver's error flag. A high flag sends the held codeword again. A low flag returns the block to idle, where it can take the next word. The number of resends is bounded by a parameter. If the receiver still reports an error after the final permitted resend, a sticky failure output is raised and the block returns to idle.

Top module: `ham74_serial_tx`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `ser_o`, `frame_valid_o`, `busy_o` and `fail_o` are all 0.
- R2: The codeword positions 1 to 7 carry p1, p2, d1, p3, d2, d3, d4. Here d1..d4 are `data_i[0]`..`data_i[3]`, p1 = d1^d2^d4, p2 = d1^d3^d4 and p3 = d2^d3^d4.
- R3: A load accepted at a clock edge makes `frame_valid_o` high from that edge for exactly 7 consecutive cycles. During those cycles `ser_o` presents positions 1 to 7 in that order, one per cycle.
- R4: `busy_o` rises at the edge that accepts a load and stays high until the block returns to idle. A load is accepted only while `busy_o` is low.
- R5: `err_i` is sampled in the single cycle that directly follows the last bit of a frame. If it is high and resends remain, the same frame starts again in the next cycle, so each frame with its wait takes 8 cycles.
- R6: If `err_i` is low in the wait cycle, `busy_o` falls at the end of that cycle.
- R7: A resend carries the bits latched at load, even if `data_i` has changed since.
- R8: A load strobe that arrives while `busy_o` is high has no effect: no extra frame is sent and the held codeword is unchanged.
- R9: At most MAX_RETRY resends follow the first frame (default 3). An error flag in the wait cycle of the last permitted frame sets `fail_o` and returns the block to idle.
- R10: `fail_o` stays high until reset, and the block keeps accepting and sending new words while it is high.
- R11: `ser_o` is 0 whenever `frame_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Load strobe for `data_i`, honoured only when idle |
| data_i | input | 4 | Result word to encode |
| err_i | input | 1 | Error flag from the receiver, sampled in the wait cycle |
| ser_o | output | 1 | Serial codeword bit |
| frame_valid_o | output | 1 | High while a codeword bit is on `ser_o` |
| busy_o | output | 1 | High from load acceptance until return to idle |
| fail_o | output | 1 | Sticky: resend limit exhausted |

## Verification
The checker assumes that `err_i` is meaningful only in the wait cycle. It also assumes that the receiver never pulls `frame_valid_o` or the load path out of step, so its properties cover only output shape, busy framing and the stickiness of failure. The bench drives `err_i` from a response queue, and only in the cycle right after a frame ends; in every other cycle it holds the flag low. Loads are issued on the falling edge. Stray loads during a transfer are placed well inside the busy window, so they never coincide with the cycle in which the block returns to idle.

// File: rtl/ham74_tx_pkg.sv
package ham74_tx_pkg;
  localparam int unsigned DATA_W = 4;
  localparam int unsigned CODE_W = 7;
  localparam int unsigned IDX_W  = $clog2(CODE_W);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/ham74_rst_sync.sv
module ham74_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ham74_encoder.sv
module ham74_encoder
  import ham74_tx_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  logic d1, d2, d3, d4;

  always_comb begin
    d1 = data_i[0];
    d2 = data_i[1];
    d3 = data_i[2];
    d4 = data_i[3];
    // code_o[k] holds codeword position k+1
    code_o[0] = d1 ^ d2 ^ d4;
    code_o[1] = d1 ^ d3 ^ d4;
    code_o[2] = d1;
    code_o[3] = d2 ^ d3 ^ d4;
    code_o[4] = d2;
    code_o[5] = d3;
    code_o[6] = d4;
  end
endmodule

// File: rtl/ham74_frame_shift.sv
module ham74_frame_shift
  import ham74_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CODE_W-1:0] code_i,
  input  logic              shift_en,
  output logic              bit_o,
  output logic              last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_W - 1);

  logic [CODE_W-1:0] hold_q;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;

  always_comb begin
    idx_en = load_en | shift_en;
    idx_d  = idx_q;
    if (load_en)             idx_d = '0;
    else if (idx_q == LAST_IDX) idx_d = '0;
    else                     idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (load_en) hold_q <= code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign bit_o  = hold_q[idx_q];
  assign last_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/ham74_retry_ctrl.sv
module ham74_retry_ctrl #(
  parameter int unsigned MAX_RETRY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic exhausted_o
);
  localparam int unsigned CNT_W = (MAX_RETRY < 2) ? 1 : $clog2(MAX_RETRY + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RETRY);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign exhausted_o = (cnt_q == LIMIT);
endmodule

// File: rtl/ham74_serial_tx.sv
module ham74_serial_tx
  import ham74_tx_pkg::*;
#(
  parameter int unsigned MAX_RETRY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              err_i,
  output logic              ser_o,
  output logic              frame_valid_o,
  output logic              busy_o,
  output logic              fail_o
);
  logic              rst_int_n;
  logic [CODE_W-1:0] code_w;
  tx_state_e         state_q, state_d;
  logic              load_acc, shift_en, retry_inc, fail_set;
  logic              bit_w, last_w, exhausted_w;
  logic              fail_q;

  ham74_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ham74_encoder i_enc (
    .data_i (data_i),
    .code_o (code_w)
  );

  ham74_frame_shift i_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_en  (load_acc),
    .code_i   (code_w),
    .shift_en (shift_en),
    .bit_o    (bit_w),
    .last_o   (last_w)
  );

  ham74_retry_ctrl #(.MAX_RETRY(MAX_RETRY)) i_retry (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .clr_i       (load_acc),
    .inc_i       (retry_inc),
    .exhausted_o (exhausted_w)
  );

  always_comb begin
    state_d   = state_q;
    load_acc  = 1'b0;
    shift_en  = 1'b0;
    retry_inc = 1'b0;
    fail_set  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (load_i) begin
          load_acc = 1'b1;
          state_d  = ST_SEND;
        end
      end
      ST_SEND: begin
        shift_en = 1'b1;
        if (last_w) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (err_i) begin
          if (exhausted_w) begin
            fail_set = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            retry_inc = 1'b1;
            state_d   = ST_SEND;
          end
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    fail_q <= 1'b0;
    else if (fail_set) fail_q <= 1'b1;
  end

  assign frame_valid_o = (state_q == ST_SEND);
  assign ser_o         = frame_valid_o & bit_w;
  assign busy_o        = (state_q != ST_IDLE);
  assign fail_o        = fail_q;
endmodule

// File: rtl/ham74_tx_checker.sv
module ham74_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic load_i,
  input logic err_i,
  input logic ser_o,
  input logic frame_valid_o,
  input logic busy_o,
  input logic fail_o
);
  logic [3:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= 4'd0;
    else if (frame_valid_o) run_q <= run_q + 4'd1;
    else                    run_q <= 4'd0;
  end

  a_r11_ser_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid_o |-> !ser_o);

  a_r4_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |-> busy_o);

  a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |-> run_q < 4'd7);

  a_r3_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_valid_o) |-> run_q == 4'd7);

  a_r4_start_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> frame_valid_o && $past(load_i));

  a_r6_idle_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !$past(frame_valid_o));

  a_r5_resend_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_valid_o) && $past(busy_o)) |-> $past(err_i));

  a_r9_fail_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> !busy_o);

  a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> fail_o);
endmodule

bind ham74_serial_tx ham74_tx_checker i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .load_i        (load_i),
  .err_i         (err_i),
  .ser_o         (ser_o),
  .frame_valid_o (frame_valid_o),
  .busy_o        (busy_o),
  .fail_o        (fail_o)
);

// File: tb/test_ham74_serial_tx.sv
module test_ham74_serial_tx;
  localparam int MAXR = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [3:0] data_i = 4'h0;
  logic       err_i = 1'b0;
  logic       ser_o, frame_valid_o, busy_o, fail_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  bit exp_bits[$];
  bit err_resp[$];
  bit prev_valid = 1'b0;
  int run_len = 0;

  always #2 clk = ~clk;

  ham74_serial_tx #(.MAX_RETRY(MAXR)) i_ham74_serial_tx (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i), .err_i(err_i),
    .ser_o(ser_o), .frame_valid_o(frame_valid_o), .busy_o(busy_o), .fail_o(fail_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [6:0] encode(input logic [3:0] d);
    logic p1, p2, p3;
    p1 = d[0] ^ d[1] ^ d[3];
    p2 = d[0] ^ d[2] ^ d[3];
    p3 = d[1] ^ d[2] ^ d[3];
    return {d[3], d[2], d[1], p3, d[0], p2, p1};
  endfunction

  // Monitor and receiver model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      err_i <= 1'b0;
      if (frame_valid_o) begin
        run_len++;
        if (exp_bits.size() == 0) begin
          chk(1'b0, "R8 unexpected frame bit", 1, 0);
        end else begin
          bit e;
          e = exp_bits.pop_front();
          chk(ser_o == e, "R2/R3/R7 serial bit", ser_o, e);
        end
      end else begin
        chk(ser_o == 1'b0, "R11 ser quiet", ser_o, 0);
        if (prev_valid) begin
          chk(run_len == 7, "R3 frame length", run_len, 7);
          chk(busy_o == 1'b1, "R5 wait cycle busy", busy_o, 1);
          run_len = 0;
          if (err_resp.size() > 0) err_i <= err_resp.pop_front();
        end
      end
      prev_valid = frame_valid_o;
    end
  end

  task automatic send_word(input logic [3:0] d, input int nerr, input bit stray);
    int frames, busy_cnt;
    logic [6:0] cw;
    bit exp_fail;
    exp_fail = (nerr > MAXR) || fail_o;
    frames = ((nerr > MAXR) ? MAXR : nerr) + 1;
    cw = encode(d);
    for (int f = 0; f < frames; f++) begin
      for (int b = 0; b < 7; b++) exp_bits.push_back(cw[b]);
      err_resp.push_back(f < nerr);
    end
    @(negedge clk);
    data_i = d;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    chk(frame_valid_o == 1'b1, "R3 start latency", frame_valid_o, 1);
    chk(busy_o == 1'b1, "R4 busy on accept", busy_o, 1);
    busy_cnt = 1;
    while (busy_o) begin
      @(negedge clk);
      if (stray && busy_cnt == 3) begin
        data_i = ~d;
        load_i = 1'b1;
      end else begin
        load_i = 1'b0;
      end
      if (busy_o) busy_cnt++;
    end
    load_i = 1'b0;
    chk(busy_cnt == frames * 8, "R5/R6/R9 busy cycles", busy_cnt, frames * 8);
    chk(fail_o == exp_fail, "R9/R10 fail flag", fail_o, exp_fail);
    repeat (4) @(negedge clk);
    chk(frame_valid_o == 1'b0 && busy_o == 1'b0, "R8 stays idle", busy_o, 0);
    chk(exp_bits.size() == 0, "R3 all bits sent", exp_bits.size(), 0);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ser_o == 0 && frame_valid_o == 0, "R1 reset outputs", ser_o, 0);
    chk(busy_o == 0 && fail_o == 0, "R1 reset status", busy_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_o == 0 && fail_o == 0 && ser_o == 0, "R1 after release", busy_o, 0);
    repeat (2) @(negedge clk);

    send_word(4'h0, 0, 1'b0);   // R2 all-zero
    send_word(4'hF, 0, 1'b0);   // R2 all-one
    send_word(4'h5, 1, 1'b0);   // R5 single resend
    send_word(4'hA, 2, 1'b1);   // R7, R8 stray load during busy
    send_word(4'h3, MAXR, 1'b1);// R9 last permitted resend succeeds
    send_word(4'hC, MAXR + 1, 1'b0); // R9 exhaust -> fail
    send_word(4'h9, 0, 1'b0);   // R10 still works, fail sticky
    send_word(4'h6, 1, 1'b1);   // R10 with resend

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(fail_o == 1'b0, "R1/R10 fail cleared by reset", fail_o, 0);
    finish_up();
  end
endmodule